// File: doc/BRIEF.md
# Filter Output Rounding and Saturation Stage

This block turns the wide signed accumulator sum of a fixed-point filter into a narrow signed output sample. The accumulator carries `FRAC_W` fraction bits that come from the coefficient format. The first pipeline section removes those bits. It does so either by plain truncation or by symmetric rounding, which adds a slightly smaller constant to negative sums than to non-negative ones. This cancels the small DC offset that ordinary round-half-up would introduce.

The second section fits the rounded integer into `OUT_W` bits. It either clamps to the nearest representable extreme or keeps only the low bits, so the value wraps around. The rounding choice and the overflow choice are both compile-time parameters.

The stage sits after the last multiply-add of a filter. It is driven by the same clock enable as that filter, and it adds exactly three enabled cycles of latency.

Top module: `fir_out_cond`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline register clears, so `y_o` reads 0 after that edge.
- R2: A sample on `acc_i` that is captured at an edge where `ce` is high appears on `y_o` after the second following edge at which `ce` is high, giving three enabled edges in total.
- R3: With `ROUND_EN=1`, a non-negative sum has 2^(FRAC_W-1) added and a negative sum has 2^(FRAC_W-1)-1 added. The low `FRAC_W` bits are then dropped with a floor shift. As a result, exact halves round away from zero: +0.5 gives 1 and -0.5 gives -1, while -0.484 gives 0.
- R4: With `ROUND_EN=0`, the low `FRAC_W` bits are dropped with a floor shift, which rounds toward minus infinity (-1.5 gives -2).
- R5: With `SAT_EN=1`, a result above 2^(OUT_W-1)-1 gives 2^(OUT_W-1)-1, and a result below -2^(OUT_W-1) gives -2^(OUT_W-1). This also covers a result that overflows only because of the rounding carry.
- R6: With `SAT_EN=0`, `y_o` holds the low `OUT_W` bits of the two's-complement rounded result.
- R7: At an edge where `ce` is low, no register changes and `y_o` holds its value, whatever `acc_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all pipeline registers |
| acc_i | input | IN_W | Signed full-precision sum with FRAC_W fraction bits |
| y_o | output | OUT_W | Signed conditioned output sample |

## Verification
There are two kinds of internal fault to catch. A wrong rounding bias shows at the ports as a one-LSB error on inputs that sit exactly on, or just beside, a half-LSB boundary. A wrong overflow decision shows as a sign flip, or as a wrapped value where a clamped value was due. Either one appears three enabled edges after the sample that triggers it. A pipeline register that moves while `ce` is low shows up as a change in `y_o` at the very next stalled edge. Out-of-step latency causes every later comparison to miss.

// File: rtl/fir_oc_pkg.sv
package fir_oc_pkg;

    typedef enum logic [1:0] {
        OVF_NONE = 2'd0,
        OVF_POS  = 2'd1,
        OVF_NEG  = 2'd2
    } ovf_e;

    localparam int DEF_IN_W   = 20;
    localparam int DEF_FRAC_W = 6;
    localparam int DEF_OUT_W  = 10;

    // width of the value left after the fraction is dropped (one guard bit kept)
    function automatic int rounded_width(input int in_w, input int frac_w);
        return in_w + 1 - frac_w;
    endfunction

endpackage

// File: rtl/oc_round.sv
module oc_round
    import fir_oc_pkg::*;
#(
    parameter int IN_W     = DEF_IN_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter bit ROUND_EN = 1'b1,
    localparam int EXT_W   = IN_W + 1,
    localparam int RW      = rounded_width(IN_W, FRAC_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [IN_W-1:0]      acc_i,
    output logic [RW-1:0]        rnd_o
);

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] sum_q;

    assign ext = {acc_i[IN_W-1], acc_i};

    generate
        if (ROUND_EN && FRAC_W > 0) begin : g_sym
            localparam logic [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC_W - 1);
            // negatives get one less than half, so ties move away from zero on both sides
            always_comb begin
                if (acc_i[IN_W-1]) bias = HALF - EXT_W'(1);
                else               bias = HALF;
            end
        end else begin : g_trunc
            assign bias = '0;
        end
    endgenerate

    // section 1: full-width biased sum
    always_ff @(posedge clk) begin
        if (rst)     sum_q <= '0;
        else if (ce) sum_q <= ext + bias;
    end

    // section 2: discard fraction (floor by slicing the signed value)
    always_ff @(posedge clk) begin
        if (rst)     rnd_o <= '0;
        else if (ce) rnd_o <= sum_q[EXT_W-1:FRAC_W];
    end

endmodule

// File: rtl/oc_ovf_detect.sv
module oc_ovf_detect
    import fir_oc_pkg::*;
#(
    parameter int RW    = 15,
    parameter int OUT_W = DEF_OUT_W,
    localparam int TOP_W = RW - OUT_W + 1
) (
    input  logic [RW-1:0] val_i,
    output ovf_e          ovf_o
);

    logic [TOP_W-1:0] top;
    logic             fits;

    assign top  = val_i[RW-1:OUT_W-1];
    assign fits = (&top) | ~(|top);

    always_comb begin
        if (fits)              ovf_o = OVF_NONE;
        else if (val_i[RW-1])  ovf_o = OVF_NEG;
        else                   ovf_o = OVF_POS;
    end

endmodule

// File: rtl/oc_sat.sv
module oc_sat
    import fir_oc_pkg::*;
#(
    parameter int RW     = 15,
    parameter int OUT_W  = DEF_OUT_W,
    parameter bit SAT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [RW-1:0]     val_i,
    output logic [OUT_W-1:0]  y_o
);

    localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MAX_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] nxt;

    generate
        if (SAT_EN) begin : g_clamp
            ovf_e ovf;
            oc_ovf_detect #(.RW(RW), .OUT_W(OUT_W)) u_det (
                .val_i (val_i),
                .ovf_o (ovf)
            );
            always_comb begin
                case (ovf)
                    OVF_POS: nxt = MAX_POS;
                    OVF_NEG: nxt = MAX_NEG;
                    default: nxt = val_i[OUT_W-1:0];
                endcase
            end
        end else begin : g_wrap
            assign nxt = val_i[OUT_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)     y_o <= '0;
        else if (ce) y_o <= nxt;
    end

endmodule

// File: rtl/fir_out_cond.sv
module fir_out_cond
    import fir_oc_pkg::*;
#(
    parameter int IN_W     = DEF_IN_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter int OUT_W    = DEF_OUT_W,
    parameter bit ROUND_EN = 1'b1,
    parameter bit SAT_EN   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [IN_W-1:0]  acc_i,
    output logic [OUT_W-1:0] y_o
);

    localparam int RW = rounded_width(IN_W, FRAC_W);

    logic [RW-1:0] rnd_w;

    oc_round #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ROUND_EN(ROUND_EN)) u_rnd (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .acc_i (acc_i),
        .rnd_o (rnd_w)
    );

    oc_sat #(.RW(RW), .OUT_W(OUT_W), .SAT_EN(SAT_EN)) u_sat (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .val_i (rnd_w),
        .y_o   (y_o)
    );

endmodule

// File: rtl/fir_out_cond_chk.sv
module fir_out_cond_chk #(
    parameter int IN_W   = 20,
    parameter int OUT_W  = 10,
    parameter int RW     = 15,
    parameter bit SAT_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic [IN_W-1:0]  acc_i,
    input logic [RW-1:0]    rnd_q,
    input logic [OUT_W-1:0] y_o
);

    // R1: reset empties the output register
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (y_o == '0));

    // R7: stalled edge leaves the output untouched
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(y_o));

    // R3: a non-negative sum never rounds to a negative value
    a_r3_nonneg_stays_nonneg: assert property (@(posedge clk) disable iff (rst)
        (ce && $past(ce) && !$past(acc_i[IN_W-1])) |=> !rnd_q[RW-1]);

    generate
        if (SAT_EN) begin : g_sat_chk
            // R5: clamping keeps the sign of the rounded value
            a_r5_sat_sign_pos: assert property (@(posedge clk) disable iff (rst)
                (ce && !rnd_q[RW-1]) |=> !y_o[OUT_W-1]);
            a_r5_sat_sign_neg: assert property (@(posedge clk) disable iff (rst)
                (ce && rnd_q[RW-1]) |=> y_o[OUT_W-1]);
        end
    endgenerate

endmodule

bind fir_out_cond fir_out_cond_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .RW(RW), .SAT_EN(SAT_EN)
) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .acc_i(acc_i), .rnd_q(rnd_w), .y_o(y_o)
);

// File: tb/sim_fir_out_cond.sv
module sim_fir_out_cond;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W   = 20;
    localparam int FRAC_W = 6;
    localparam int OUT_W  = 10;
    localparam longint HALF = 64'sd1 <<< (FRAC_W - 1);
    localparam longint OMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
    localparam longint OMIN = -(64'sd1 <<< (OUT_W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic [IN_W-1:0]  acc = '0;
    logic [OUT_W-1:0] y_a, y_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        longint           x;
        logic [OUT_W-1:0] exp_a;
        logic [OUT_W-1:0] exp_b;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // u0: symmetric rounding with clamping; u1: truncation with wrap-around
    fir_out_cond #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
                   .ROUND_EN(1'b1), .SAT_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .acc_i(acc), .y_o(y_a));

    fir_out_cond #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
                   .ROUND_EN(1'b0), .SAT_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .ce(ce), .acc_i(acc), .y_o(y_b));

    function automatic longint ref_round(longint x, bit sym);
        if (!sym)    return x >>> FRAC_W;
        if (x >= 0)  return (x + HALF) >>> FRAC_W;
        return (x + HALF - 1) >>> FRAC_W;
    endfunction

    function automatic logic [OUT_W-1:0] ref_fit(longint v, bit clamp);
        longint w;
        w = v;
        if (clamp && v > OMAX) w = OMAX;
        if (clamp && v < OMIN) w = OMIN;
        return w[OUT_W-1:0];
    endfunction

    task automatic check(string tag, logic [OUT_W-1:0] got, logic [OUT_W-1:0] exp, longint x);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s x=%0d actual=%0d expected=%0d", tag, x,
                     $signed(got), $signed(exp));
        end
    endtask

    task automatic send(longint x);
        item_t it;
        @(negedge clk);
        ce  = 1'b1;
        acc = x[IN_W-1:0];
        it.x     = x;
        it.exp_a = ref_fit(ref_round(x, 1'b1), 1'b1);
        it.exp_b = ref_fit(ref_round(x, 1'b0), 1'b0);
        sb.push_back(it);
    endtask

    task automatic stall(longint junk);
        @(negedge clk);
        ce  = 1'b0;
        acc = junk[IN_W-1:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard three enabled edges after each push
    initial begin : monitor
        int n = 0;
        logic [OUT_W-1:0] pa = '0;
        logic [OUT_W-1:0] pb = '0;
        bit en_edge;
        item_t it;
        forever begin
            @(posedge clk);
            en_edge = ce;
            if (rst) begin
                n = 0;
                #1;
                pa = y_a; pb = y_b;
            end else if (en_edge) begin
                n++;
                #1;
                if (n >= 3 && sb.size() > 0) begin
                    it = sb.pop_front();
                    check("R2 R3 R5 u0", y_a, it.exp_a, it.x);
                    check("R2 R4 R6 u1", y_b, it.exp_b, it.x);
                end
                pa = y_a; pb = y_b;
            end else begin
                #1;
                check("R7 u0 hold", y_a, pa, -1);
                check("R7 u1 hold", y_b, pb, -1);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : driver
        ce  = 1'b1;
        acc = 20'h7A5C3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ce  = 1'b0;
        #1;
        // R1: outputs cleared by reset even with ce high and input nonzero
        check("R1 u0 reset", y_a, '0, 0);
        check("R1 u1 reset", y_b, '0, 0);

        // half-LSB boundaries
        send(0);
        send(32);        // +0.5
        send(-32);       // -0.5
        send(-33);
        send(-31);
        send(31);
        send(95);
        send(-96);       // -1.5
        send(-95);
        stall(12345);
        stall(-4000);
        // overflow cases, including one caused only by the rounding carry
        send(32736);     // 511.5
        send(32735);
        send(-32768);    // -512.0
        send(-32769);
        send(-32801);    // -512.52
        send((64'sd1 <<< (IN_W-1)) - 1);
        send(-(64'sd1 <<< (IN_W-1)));
        stall(99);
        send(40000);
        send(-40000);
        // sweep with periodic stalls
        for (int k = 0; k < 60; k++) begin
            send(k * 1237 - 37000);
            if (k % 7 == 3) stall(k * 555);
        end
        // flush the pipeline
        send(0); send(0); send(0);
        stall(0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule